// File: doc/BRIEF.md
# Bias Current Calibration Sequencer

This block is the digital half of a reference-current trim loop. A bank of current outputs is built from one global DAC and one local DAC per output copy. The sequencer first trims the global DAC code until output 0 matches an external reference. It then visits each local copy in turn and trims that copy's local DAC until the copy matches output 0. Once the pass is complete, it returns the comparator to output 0 and keeps nudging the global code, so that every output follows slow voltage and temperature drift.

The analog side provides a single comparator decision, `cmpUp`. The value 1 means the observed output is below its target and the code must rise. The analog side also switches a mux under the sequencer's control. Each mux change is a request/acknowledge exchange followed by a programmable settle time. A phase is judged complete when the comparator reverses direction `TOGGLE_CNT` times in a row, which shows that the code is dithering about the target.

Top module: `biasCalTop`

## Requirements
- R1: In reset and after reset with no start, every DAC code is at midscale (2^(CODE_W-1), 32 by default), `muxSel` is 0, and `selReq`, `busy`, `done`, `tracking` and `rangeErr` are all 0.
- R2: A `start` pulse seen while idle begins the master phase. `muxSel` becomes 0 and `busy` rises. `selReq` stays high, with `muxSel` unchanged, until `selAck` is seen.
- R3: After `selAck`, no code changes for at least `settleCycles` cycles. Trimming then resumes.
- R4: While `muxSel` is 0, only the global code may change. It moves by exactly +1 when `cmpUp` was 1 and by -1 when it was 0, at most one step per cycle.
- R5: A trim phase ends on the `TOGGLE_CNT`-th consecutive direction reversal (default 3). With a dithering comparator, a code that starts at or below its target T ends at T, and one that starts above T ends at T+1.
- R6: After the master phase, local copies 1 to NUM_LOCAL are selected in ascending order. While copy k is selected, only local code k changes. The select sequence of one pass is 0,1,...,NUM_LOCAL,0. Local code k occupies bits [(k-1)*CODE_W +: CODE_W] of `localCodes`.
- R7: When the last copy finishes, output 0 is reselected. After settling, `done` pulses for exactly one cycle, `busy` falls and `tracking` rises.
- R8: In tracking, the global code keeps following the comparator, so that it dithers between T and T+1 of a new target. The local codes hold their values.
- R9: Codes saturate at 0 and at 2^CODE_W-1. `rangeErr` goes to 1 when a step lands on either end, and it stays set until restart.
- R10: A `restart` pulse in any state returns all codes to midscale, clears `rangeErr`, raises `busy` and begins the master phase with `muxSel` 0.
- R11: `start` has no effect unless the block is idle. A start pulse during tracking leaves `busy` at 0 and `tracking` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin calibration from idle |
| restart | input | 1 | Synchronous restart of the whole sequence |
| cmpUp | input | 1 | Comparator decision, 1 = output below target |
| selAck | input | 1 | Mux has switched to `muxSel` |
| settleCycles | input | SETTLE_W | Wait after each mux change before sampling |
| globalCode | output | CODE_W | Global DAC code |
| localCodes | output | NUM_LOCAL*CODE_W | Local DAC codes, copy 1 in the low bits |
| muxSel | output | SEL_W | Output compared: 0 = master, k = copy k |
| selReq | output | 1 | Request to switch the mux to `muxSel` |
| busy | output | 1 | Calibration pass in progress |
| done | output | 1 | One-cycle pulse when a pass completes |
| tracking | output | 1 | Continuous drift tracking on the master |
| rangeErr | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that `selAck` is only raised while `selReq` is high, and that `restart` and `start` are synchronous single-cycle pulses. The bench's acknowledge model holds `selAck` low whenever no request is pending, and it raises `selAck` only after a randomized lag. The comparator model derives `cmpUp` from the currently selected code and a hidden target, so each decision is consistent with the mux position. Targets are drawn away from the code ends, except in the saturation cases, where the comparator is forced to one direction on purpose.

// File: rtl/biasCalPkg.sv
package biasCalPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_SETTLE,
    ST_TRIM,
    ST_TRACK
  } calState_e;

  // Strobes from the sequencer to the code datapath.
  typedef struct packed {
    logic       clearAll;
    logic       step;
    logic       stepUp;
    logic [7:0] target;   // 0 = global code, k = local code k
  } pathStrobe_t;

endpackage

// File: rtl/biasCalCounter.sv
module biasCalCounter #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              en,
  input  logic              up,
  output logic [CODE_W-1:0] code,
  output logic              hitEnd
);

  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      code <= MID_CODE;
    end else if (en) begin
      if (up && code != MAX_CODE) begin
        code <= code + 1'b1;
      end else if (!up && code != '0) begin
        code <= code - 1'b1;
      end
    end
  end

  // The step about to happen lands on (or stays at) an end of the range.
  always_comb begin
    hitEnd = en && ((up && code >= MAX_CODE - 1'b1) || (!up && code <= CODE_W'(1)));
  end

  p_step_up_r4: assert property (@(posedge clk) disable iff (!rstN)
    (en && up && !clear && code != MAX_CODE) |=> code == $past(code) + 1'b1);

  p_step_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    (en && !up && !clear && code != '0) |=> code == $past(code) - 1'b1);

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!en && !clear) |=> $stable(code));

endmodule

// File: rtl/biasCalPath.sv
module biasCalPath
  import biasCalPkg::*;
#(
  parameter int NUM_LOCAL = 4,
  parameter int CODE_W    = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pathStrobe_t                   strb,
  output logic [CODE_W-1:0]             globalCode,
  output logic [NUM_LOCAL*CODE_W-1:0]   localCodes,
  output logic                          rangeErr
);

  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [NUM_LOCAL:0] hits;
  logic               globalEn;

  assign globalEn = strb.step && (strb.target == 8'd0);

  biasCalCounter #(.CODE_W(CODE_W)) globalCnt_i (
    .clk    (clk),
    .rstN   (rstN),
    .clear  (strb.clearAll),
    .en     (globalEn),
    .up     (strb.stepUp),
    .code   (globalCode),
    .hitEnd (hits[0])
  );

  for (genvar k = 0; k < NUM_LOCAL; k++) begin : g_local
    logic localEn;
    assign localEn = strb.step && (strb.target == 8'(k + 1));

    biasCalCounter #(.CODE_W(CODE_W)) localCnt_i (
      .clk    (clk),
      .rstN   (rstN),
      .clear  (strb.clearAll),
      .en     (localEn),
      .up     (strb.stepUp),
      .code   (localCodes[k*CODE_W +: CODE_W]),
      .hitEnd (hits[k+1])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clearAll) begin
      rangeErr <= 1'b0;
    end else if (|hits) begin
      rangeErr <= 1'b1;
    end
  end

  p_range_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rangeErr && !strb.clearAll) |=> rangeErr);

  p_local_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.target == 8'd0 && !strb.clearAll) |=> $stable(localCodes));

  p_clear_mid_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (globalCode == MID_CODE && !rangeErr));

endmodule

// File: rtl/biasCalCtrl.sv
module biasCalCtrl
  import biasCalPkg::*;
#(
  parameter int NUM_LOCAL  = 4,
  parameter int TOGGLE_CNT = 3,
  parameter int SETTLE_W   = 8,
  parameter int SEL_W      = $clog2(NUM_LOCAL + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                restart,
  input  logic                cmpUp,
  input  logic                selAck,
  input  logic [SETTLE_W-1:0] settleCycles,
  output pathStrobe_t         strb,
  output logic [SEL_W-1:0]    muxSel,
  output logic                selReq,
  output logic                busy,
  output logic                done,
  output logic                tracking
);

  localparam int RUN_W = $clog2(TOGGLE_CNT + 1);
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_LOCAL);
  localparam logic [RUN_W-1:0] RUN_DONE = RUN_W'(TOGGLE_CNT);

  calState_e           state;
  logic [SEL_W-1:0]    selQ;
  logic                toTrack;
  logic [SETTLE_W-1:0] settleCnt;
  logic                lastDir;
  logic                hasLast;
  logic [RUN_W-1:0]    runCnt;
  logic [RUN_W-1:0]    newRun;
  logic                stepping;

  always_comb begin
    stepping      = (state == ST_TRIM) || (state == ST_TRACK);
    newRun        = (hasLast && (cmpUp != lastDir)) ? runCnt + 1'b1 : '0;
    strb.clearAll = restart;
    strb.step     = stepping && !restart;
    strb.stepUp   = cmpUp;
    strb.target   = 8'(selQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      selQ      <= '0;
      toTrack   <= 1'b0;
      settleCnt <= '0;
      lastDir   <= 1'b0;
      hasLast   <= 1'b0;
      runCnt    <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else if (restart) begin
      state     <= ST_SELECT;
      selQ      <= '0;
      toTrack   <= 1'b0;
      settleCnt <= '0;
      hasLast   <= 1'b0;
      runCnt    <= '0;
      busy      <= 1'b1;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_SELECT;
            selQ  <= '0;
            busy  <= 1'b1;
          end
        end
        ST_SELECT: begin
          if (selAck) begin
            state     <= ST_SETTLE;
            settleCnt <= '0;
          end
        end
        ST_SETTLE: begin
          if (settleCnt >= settleCycles) begin
            if (toTrack) begin
              state <= ST_TRACK;
              done  <= 1'b1;
              busy  <= 1'b0;
            end else begin
              state <= ST_TRIM;
            end
          end else begin
            settleCnt <= settleCnt + 1'b1;
          end
        end
        ST_TRIM: begin
          lastDir <= cmpUp;
          hasLast <= 1'b1;
          runCnt  <= newRun;
          if (newRun == RUN_DONE) begin
            hasLast <= 1'b0;
            runCnt  <= '0;
            state   <= ST_SELECT;
            if (selQ == LAST_SEL) begin
              selQ    <= '0;
              toTrack <= 1'b1;
            end else begin
              selQ <= selQ + 1'b1;
            end
          end
        end
        ST_TRACK: begin
          state <= ST_TRACK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign muxSel   = selQ;
  assign selReq   = (state == ST_SELECT);
  assign tracking = (state == ST_TRACK);

  p_sel_wait_r2: assert property (@(posedge clk) disable iff (!rstN)
    (selReq && !selAck && !restart) |=> (selReq && $stable(muxSel)));

  p_sel_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    muxSel <= LAST_SEL);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_track_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    tracking |-> (!busy && muxSel == '0));

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    (tracking && !restart) |=> tracking);

endmodule

// File: rtl/biasCalTop.sv
module biasCalTop
  import biasCalPkg::*;
#(
  parameter int NUM_LOCAL  = 4,
  parameter int CODE_W     = 6,
  parameter int TOGGLE_CNT = 3,
  parameter int SETTLE_W   = 8,
  parameter int SEL_W      = $clog2(NUM_LOCAL + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic                        restart,
  input  logic                        cmpUp,
  input  logic                        selAck,
  input  logic [SETTLE_W-1:0]         settleCycles,
  output logic [CODE_W-1:0]           globalCode,
  output logic [NUM_LOCAL*CODE_W-1:0] localCodes,
  output logic [SEL_W-1:0]            muxSel,
  output logic                        selReq,
  output logic                        busy,
  output logic                        done,
  output logic                        tracking,
  output logic                        rangeErr
);

  pathStrobe_t strb;

  biasCalCtrl #(
    .NUM_LOCAL  (NUM_LOCAL),
    .TOGGLE_CNT (TOGGLE_CNT),
    .SETTLE_W   (SETTLE_W),
    .SEL_W      (SEL_W)
  ) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .restart      (restart),
    .cmpUp        (cmpUp),
    .selAck       (selAck),
    .settleCycles (settleCycles),
    .strb         (strb),
    .muxSel       (muxSel),
    .selReq       (selReq),
    .busy         (busy),
    .done         (done),
    .tracking     (tracking)
  );

  biasCalPath #(
    .NUM_LOCAL (NUM_LOCAL),
    .CODE_W    (CODE_W)
  ) path_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .globalCode (globalCode),
    .localCodes (localCodes),
    .rangeErr   (rangeErr)
  );

endmodule

// File: tb/biasCalTop_tb_top.sv
`timescale 1ns/100ps
module biasCalTop_tb_top;

  localparam int NL    = 4;
  localparam int CW    = 6;
  localparam int SW    = 8;
  localparam int SELW  = $clog2(NL + 1);
  localparam int MID   = 32;
  localparam int MAXC  = 63;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rstN, start, restart, cmpUp, selAck;
  logic [SW-1:0]  settleCycles;
  logic [CW-1:0]  globalCode;
  logic [NL*CW-1:0] localCodes;
  logic [SELW-1:0]  muxSel;
  logic selReq, busy, done, tracking, rangeErr;

  biasCalTop #(.NUM_LOCAL(NL), .CODE_W(CW), .TOGGLE_CNT(3), .SETTLE_W(SW)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .restart(restart), .cmpUp(cmpUp),
    .selAck(selAck), .settleCycles(settleCycles), .globalCode(globalCode),
    .localCodes(localCodes), .muxSel(muxSel), .selReq(selReq), .busy(busy),
    .done(done), .tracking(tracking), .rangeErr(rangeErr)
  );

  int nChk = 0;
  int nBad = 0;
  int tG;
  int tL [NL+1];
  int forceMode = 0;   // 0 plant, 1 always up, 2 always down
  int ackLag = 0;
  int ackCnt = 0;

  function automatic int locCode(int k);
    return int'(localCodes[(k-1)*CW +: CW]);
  endfunction

  // Comparator plant: selected output vs hidden target.
  always_comb begin
    int s;
    s = int'(muxSel);
    if (forceMode == 1)      cmpUp = 1'b1;
    else if (forceMode == 2) cmpUp = 1'b0;
    else if (s == 0)         cmpUp = (int'(globalCode) <= tG);
    else if (s <= NL)        cmpUp = (int'(localCodes[(s-1)*CW +: CW]) <= tL[s]);
    else                     cmpUp = 1'b0;
  end

  // Mux acknowledge with a lag.
  always @(posedge clk) begin
    #1;
    if (!selReq) begin
      ackCnt = 0;
      selAck = 1'b0;
    end else if (ackCnt >= ackLag) begin
      selAck = 1'b1;
    end else begin
      ackCnt++;
    end
  end

  // Step monitor and select log.
  int prevG, prevSel, monR4, monR6, logN, doneCnt;
  int prevL [NL+1];
  int selLog [16];
  bit prevCmp, prevReq, skip;
  initial begin monR4 = 0; monR6 = 0; logN = 0; doneCnt = 0; end

  always @(negedge clk) begin
    if (!rstN) begin
      skip = 1'b1;
      prevReq = 1'b0;
    end else begin
      if (!skip) begin
        if (int'(globalCode) != prevG) begin
          if (prevSel != 0) monR4++;
          else if (prevCmp && int'(globalCode) != prevG + 1) monR4++;
          else if (!prevCmp && int'(globalCode) != prevG - 1) monR4++;
        end
        for (int k = 1; k <= NL; k++) begin
          if (locCode(k) != prevL[k]) begin
            if (prevSel != k) monR6++;
            else if (prevCmp && locCode(k) != prevL[k] + 1) monR6++;
            else if (!prevCmp && locCode(k) != prevL[k] - 1) monR6++;
          end
        end
      end
      skip = restart;
      if (restart) begin
        logN = 0;
        prevReq = 1'b0;
      end else begin
        if (selReq && !prevReq && logN < 16) begin
          selLog[logN] = int'(muxSel);
          logN++;
        end
        prevReq = selReq;
      end
      if (done) doneCnt++;
    end
    prevG = int'(globalCode);
    for (int k = 1; k <= NL; k++) prevL[k] = locCode(k);
    prevCmp = cmpUp;
    prevSel = int'(muxSel);
  end

  task automatic check(bit ok, string tag, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Final code of a trim phase with a dithering comparator (R5).
  function automatic int expFinal(int startCode, int tgt);
    int c = startCode;
    int run = 0;
    bit hasLast = 0;
    bit last = 0;
    for (int i = 0; i < 300; i++) begin
      bit up;
      int nr;
      up = (c <= tgt);
      if (up && c < MAXC) c++;
      else if (!up && c > 0) c--;
      nr = (hasLast && up != last) ? run + 1 : 0;
      last = up; hasLast = 1; run = nr;
      if (nr == 3) break;
    end
    return c;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doRestart();
    @(posedge clk); #1 restart = 1'b1;
    @(posedge clk); #1 restart = 1'b0;
    check(globalCode == CW'(MID), "R10 global midscale", int'(globalCode), MID);
    check(localCodes == {NL{CW'(MID)}}, "R10 locals midscale", int'(localCodes[CW-1:0]), MID);
    check(!rangeErr && busy && muxSel == '0, "R10 flags", {rangeErr, busy}, 1);
  endtask

  task automatic waitDone(output bit got);
    got = 0;
    for (int i = 0; i < 6000; i++) begin
      @(posedge clk); #1;
      if (done) begin got = 1; return; end
    end
  endtask

  task automatic pickTargets(int lo, int hi);
    tG = lo + int'($urandom % (hi - lo + 1));
    for (int k = 1; k <= NL; k++) tL[k] = lo + int'($urandom % (hi - lo + 1));
  endtask

  task automatic checkPass(int round);
    bit got;
    bit ok;
    int d0;
    int held [NL+1];
    d0 = doneCnt;
    waitDone(got);
    check(got, "R7 done seen", got, 1);
    check(int'(globalCode) == expFinal(MID, tG), "R5 global final", int'(globalCode), expFinal(MID, tG));
    for (int k = 1; k <= NL; k++)
      check(locCode(k) == expFinal(MID, tL[k]), "R5 local final", locCode(k), expFinal(MID, tL[k]));
    ok = (logN == NL + 2) && (selLog[NL+1] == 0);
    for (int i = 0; i <= NL; i++) if (selLog[i] != i) ok = 0;
    check(ok, "R6 select order", logN, NL + 2);
    check(tracking && !busy && muxSel == '0, "R7 tracking entry", {tracking, busy}, 2);
    cyc(1);
    check(!done && doneCnt == d0 + 1, "R7 done one cycle", doneCnt - d0, 1);
    for (int k = 1; k <= NL; k++) held[k] = locCode(k);
    tG = 8 + int'($urandom % 48);
    cyc(100);
    check(int'(globalCode) == tG || int'(globalCode) == tG + 1, "R8 global tracks", int'(globalCode), tG);
    ok = 1;
    for (int k = 1; k <= NL; k++) if (locCode(k) != held[k]) ok = 0;
    check(ok, "R8 locals hold", round, round);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    check(!busy && tracking, "R11 start ignored", {busy, tracking}, 1);
  endtask

  int cycles = 0;
  bit finished = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      nBad++; nChk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    bit got;
    void'($urandom(32'd9137));
    rstN = 0; start = 0; restart = 0; settleCycles = 8'd2;
    tG = 40;
    for (int k = 0; k <= NL; k++) tL[k] = 30;
    cyc(4);
    check(globalCode == CW'(MID) && localCodes == {NL{CW'(MID)}}, "R1 reset codes", int'(globalCode), MID);
    check(!selReq && !busy && !done && !tracking && !rangeErr && muxSel == '0, "R1 reset flags",
          {selReq, busy, done, tracking, rangeErr}, 0);
    rstN = 1;
    cyc(5);
    check(!busy && !selReq && globalCode == CW'(MID), "R1 idle after reset", busy, 0);

    // Round 0: start from idle.
    pickTargets(8, 55);
    ackLag = 2;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    check(busy && selReq && muxSel == '0, "R2 start begins master", {busy, selReq}, 3);
    cyc(1);
    check(selReq && muxSel == '0, "R2 request held until ack", selReq, 1);
    checkPass(0);

    // Directed: targets equal to midscale, and targets below midscale.
    tG = MID; for (int k = 1; k <= NL; k++) tL[k] = MID;
    settleCycles = 8'd0; ackLag = 0;
    doRestart();
    checkPass(1);
    tG = 12; for (int k = 1; k <= NL; k++) tL[k] = 5 + 4 * k;
    settleCycles = 8'd5; ackLag = 3;
    doRestart();
    checkPass(2);

    // Random rounds.
    for (int r = 3; r < 7; r++) begin
      pickTargets(8, 55);
      settleCycles = SW'($urandom % 6);
      ackLag = int'($urandom % 4);
      doRestart();
      checkPass(r);
    end

    // Saturation high and low.
    forceMode = 1; doRestart();
    cyc(80);
    check(globalCode == CW'(MAXC) && rangeErr && busy, "R9 saturate high", int'(globalCode), MAXC);
    forceMode = 2; doRestart();
    cyc(80);
    check(globalCode == '0 && rangeErr, "R9 saturate low", int'(globalCode), 0);
    forceMode = 0; tG = 30;
    cyc(50);
    check(rangeErr, "R9 flag sticky", rangeErr, 1);

    // Long settle window.
    tG = 50; settleCycles = 8'd150; ackLag = 0;
    doRestart();
    cyc(140);
    check(globalCode == CW'(MID), "R3 no step while settling", int'(globalCode), MID);
    cyc(40);
    check(globalCode != CW'(MID), "R3 trimming after settle", int'(globalCode), MID + 1);

    check(monR4 == 0, "R4 global step rule", monR4, 0);
    check(monR6 == 0, "R6 local step rule", monR6, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule